// File: doc/BRIEF.md
# Conditional Branch Program Counter

This block holds the program counter of a small 16-bit processor and chooses, once per instruction, between stepping to the next word and jumping. On each cycle where the fetch-advance strobe is high, it looks at the fetched instruction word. If the two lowest bits mark the word as a conditional branch, the block reads a 2-bit condition code and a 12-bit absolute target from that word. The PC loads the zero-extended target only when the compare flag that the code names is set. In every other case the PC steps forward by one word.

Three compare flags arrive as inputs: equal, greater and less, produced earlier by a compare in the datapath. The block also drives a taken indication. It is a registered single-cycle pulse that is high in exactly the cycle in which the PC first shows a branch target. Fetch memory, the ALU and the way the flags are made sit outside the block.

Top module: `brcond_pc`

## Requirements
- R1: A synchronous active-high reset sets the PC to 16'h0000 and the taken output to 0 at the next clock edge, whatever the other inputs are.
- R2: On an edge where the advance strobe is low, the PC keeps its value and the taken output is 0.
- R3: On an advance edge where instruction bits [1:0] differ from 2'b10, the PC becomes PC+1 and taken is 0, whatever the flags are.
- R4: A branch word (bits [1:0] = 2'b10) whose condition code in bits [3:2] is 2'b00 loads the target when the equal flag is set.
- R5: A branch word with condition code 2'b01 loads the target when the greater flag is set.
- R6: A branch word with condition code 2'b10 loads the target when the less flag is set.
- R7: When the flag selected by the condition code is clear, a branch word advances the PC by one and taken stays 0, even if other flags are set.
- R8: Condition code 2'b11 never branches, even with all three flags set.
- R9: The loaded PC equals instruction bits [15:4] zero-extended to 16 bits, and taken is 1 in the same cycle that the new PC is first visible.
- R10: Taken is a one-cycle pulse: it returns to 0 on the next edge unless that edge also takes a branch.
- R11: Sequential stepping wraps from 16'hFFFF to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Fetch-advance strobe; the PC updates only when high |
| instr | input | 16 | Fetched instruction word |
| flag_eq | input | 1 | Compare result: equal |
| flag_gt | input | 1 | Compare result: greater |
| flag_lt | input | 1 | Compare result: less |
| pc | output | 16 | Current program counter |
| taken | output | 1 | High for one cycle when the PC has just loaded a branch target |

## Verification
Two functions can meet in one cycle: the end of a taken pulse and the taking of a new branch. The bench provokes this by applying two taken branches back to back. It expects taken to stay high across both edges and the PC to show the second target. A second collision is reset arriving together with an advancing, satisfied branch word. The bench judges this by requiring PC 0 and taken 0 on the following sample, so reset has to win over the load.

// File: rtl/brcond_pc_pkg.sv
package brcond_pc_pkg;
   typedef enum logic [1:0] {
      CC_EQ   = 2'b00,
      CC_GT   = 2'b01,
      CC_LT   = 2'b10,
      CC_RSVD = 2'b11
   } cc_e;

   localparam logic [1:0] FMT_BRANCH = 2'b10;
endpackage

// File: rtl/brcond_pc_decode.sv
module brcond_pc_decode #(
   parameter int INSTR_W  = 16,
   parameter int FMT_W    = 2,
   parameter int CC_LSB   = 2,
   parameter int TGT_LSB  = 4,
   parameter int TGT_W    = 12
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               is_branch,
   output brcond_pc_pkg::cc_e cc,
   output logic [TGT_W-1:0]   tgt
);
   localparam int CC_W    = 2;
   localparam int TGT_MSB = TGT_LSB + TGT_W - 1;

   if (FMT_W != 2) begin : g_bad_fmt
      $error("brcond_pc_decode: format field must be 2 bits");
   end
   if (CC_LSB + CC_W > TGT_LSB) begin : g_bad_cc
      $error("brcond_pc_decode: condition field overlaps target");
   end
   if (TGT_MSB >= INSTR_W) begin : g_bad_tgt
      $error("brcond_pc_decode: target field exceeds instruction width");
   end

   always_comb begin
      is_branch = (instr[FMT_W-1:0] == brcond_pc_pkg::FMT_BRANCH);
      cc        = brcond_pc_pkg::cc_e'(instr[CC_LSB +: CC_W]);
      tgt       = instr[TGT_LSB +: TGT_W];
   end
endmodule

// File: rtl/brcond_pc_cond_sel.sv
module brcond_pc_cond_sel (
   input  logic               is_branch,
   input  brcond_pc_pkg::cc_e cc,
   input  logic               flag_eq,
   input  logic               flag_gt,
   input  logic               flag_lt,
   output logic               hit
);
   logic sel_flag;

   always_comb begin
      case (cc)
         brcond_pc_pkg::CC_EQ: sel_flag = flag_eq;
         brcond_pc_pkg::CC_GT: sel_flag = flag_gt;
         brcond_pc_pkg::CC_LT: sel_flag = flag_lt;
         default:              sel_flag = 1'b0;
      endcase
      hit = is_branch & sel_flag;
   end
endmodule

// File: rtl/brcond_pc_reg.sv
module brcond_pc_reg #(
   parameter int PC_W  = 16,
   parameter int TGT_W = 12,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             load,
   input  logic [TGT_W-1:0] tgt,
   output logic [PC_W-1:0]  pc_q,
   output logic             taken_q
);
   localparam int PAD_W = PC_W - TGT_W;
   localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

   if (PAD_W < 0) begin : g_bad_pad
      $error("brcond_pc_reg: target wider than PC");
   end
   if (STEP < 1) begin : g_bad_step
      $error("brcond_pc_reg: step must be positive");
   end

   logic [PC_W-1:0] tgt_ext;

   if (PAD_W > 0) begin : g_zext
      assign tgt_ext = {{PAD_W{1'b0}}, tgt};
   end else begin : g_direct
      assign tgt_ext = tgt[PC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= '0;
         taken_q <= 1'b0;
      end else if (adv) begin
         pc_q    <= load ? tgt_ext : (pc_q + STEP_V);
         taken_q <= load;
      end else begin
         taken_q <= 1'b0;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (pc_q == '0 && !taken_q)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(pc_q) && !taken_q)); // R2
endmodule

// File: rtl/brcond_pc.sv
module brcond_pc #(
   parameter int PC_W    = 16,
   parameter int INSTR_W = 16,
   parameter int TGT_LSB = 4,
   parameter int TGT_W   = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               adv,
   input  logic [INSTR_W-1:0] instr,
   input  logic               flag_eq,
   input  logic               flag_gt,
   input  logic               flag_lt,
   output logic [PC_W-1:0]    pc,
   output logic               taken
);
   localparam int FMT_W  = 2;
   localparam int CC_LSB = 2;

   logic               is_branch;
   brcond_pc_pkg::cc_e cc;
   logic [TGT_W-1:0]   tgt;
   logic               hit;

   brcond_pc_decode #(
      .INSTR_W (INSTR_W),
      .FMT_W   (FMT_W),
      .CC_LSB  (CC_LSB),
      .TGT_LSB (TGT_LSB),
      .TGT_W   (TGT_W)
   ) u_decode (
      .instr     (instr),
      .is_branch (is_branch),
      .cc        (cc),
      .tgt       (tgt)
   );

   brcond_pc_cond_sel u_cond (
      .is_branch (is_branch),
      .cc        (cc),
      .flag_eq   (flag_eq),
      .flag_gt   (flag_gt),
      .flag_lt   (flag_lt),
      .hit       (hit)
   );

   brcond_pc_reg #(
      .PC_W  (PC_W),
      .TGT_W (TGT_W),
      .STEP  (1)
   ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .load    (hit),
      .tgt     (tgt),
      .pc_q    (pc),
      .taken_q (taken)
   );

   AST_NONBRANCH_STEPS: assert property (@(posedge clk) disable iff (rst)
      (adv && instr[1:0] != 2'b10) |=>
         (pc == PC_W'($past(pc) + 1'b1) && !taken)); // R3

   AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (rst)
      (adv && instr[1:0] == 2'b10 && instr[3:2] == 2'b11) |=> !taken); // R8

   AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
      (adv && hit) |=>
         (taken && pc == PC_W'($past(instr[TGT_LSB +: TGT_W])))); // R9

   AST_TAKEN_PULSE: assert property (@(posedge clk) disable iff (rst)
      (taken && !(adv && hit)) |=> !taken); // R10
endmodule

// File: tb/brcond_pc_tb.sv
module brcond_pc_tb;
   typedef struct packed {
      logic        adv;
      logic [15:0] ins;
      logic [2:0]  flg;   // {eq, gt, lt}
      logic [15:0] pc;
      logic        tk;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0000, 3'b100, 16'h0001, 1'b0, 8'd3},  // R3 plain word
      '{1'b1, 16'h1233, 3'b100, 16'h0002, 1'b0, 8'd3},  // R3 format 11
      '{1'b0, 16'h0122, 3'b100, 16'h0002, 1'b0, 8'd2},  // R2 no advance
      '{1'b1, 16'h0122, 3'b100, 16'h0012, 1'b1, 8'd4},  // R4 equal taken
      '{1'b1, 16'h0000, 3'b000, 16'h0013, 1'b0, 8'd10}, // R10 pulse ends
      '{1'b1, 16'h3456, 3'b010, 16'h0345, 1'b1, 8'd5},  // R5 greater taken
      '{1'b1, 16'h3456, 3'b100, 16'h0346, 1'b0, 8'd7},  // R7 wrong flag
      '{1'b1, 16'hABCA, 3'b001, 16'h0ABC, 1'b1, 8'd6},  // R6 less taken
      '{1'b1, 16'hABCA, 3'b010, 16'h0ABD, 1'b0, 8'd7},  // R7 wrong flag
      '{1'b1, 16'h777E, 3'b111, 16'h0ABE, 1'b0, 8'd8},  // R8 reserved code
      '{1'b1, 16'hFFF2, 3'b100, 16'h0FFF, 1'b1, 8'd9},  // R9 zero-extend
      '{1'b0, 16'hFFF2, 3'b100, 16'h0FFF, 1'b0, 8'd2},  // R2 hold, R10
      '{1'b1, 16'h00E2, 3'b001, 16'h1000, 1'b0, 8'd7},  // R7 eq code, lt set
      '{1'b1, 16'h0566, 3'b010, 16'h0056, 1'b1, 8'd5},  // R5
      '{1'b1, 16'h0566, 3'b010, 16'h0056, 1'b1, 8'd10}  // R10 back-to-back
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        adv = 1'b0;
   logic [15:0] instr = '0;
   logic        flag_eq = 1'b0;
   logic        flag_gt = 1'b0;
   logic        flag_lt = 1'b0;
   logic [15:0] pc;
   logic        taken;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   brcond_pc u_dut (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .instr   (instr),
      .flag_eq (flag_eq),
      .flag_gt (flag_gt),
      .flag_lt (flag_lt),
      .pc      (pc),
      .taken   (taken)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic a, input logic [15:0] w, input logic [2:0] f);
      @(negedge clk);
      adv = a; instr = w;
      {flag_eq, flag_gt, flag_lt} = f;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 pc after reset", pc, 16'h0000);
      check("R1 taken after reset", {15'd0, taken}, 16'h0000);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].adv, VECS[i].ins, VECS[i].flg);
         check($sformatf("R%0d vec %0d pc", VECS[i].req, i), pc, VECS[i].pc);
         check($sformatf("R%0d vec %0d taken", VECS[i].req, i), {15'd0, taken}, {15'd0, VECS[i].tk});
      end

      // R1: reset beats a satisfied branch on the same edge
      @(negedge clk);
      rst = 1'b1;
      apply(1'b1, 16'h0122, 3'b100);
      check("R1 reset over branch pc", pc, 16'h0000);
      check("R1 reset over branch taken", {15'd0, taken}, 16'h0000);
      @(negedge clk);
      rst = 1'b0;

      // R11: branch to 0x0FFF then step up to 0xFFFF and wrap
      apply(1'b1, 16'hFFF2, 3'b100);
      check("R9 max target", pc, 16'h0FFF);
      @(negedge clk);
      instr = 16'h0000;
      flag_eq = 1'b0;
      repeat (16'hF000) @(posedge clk);
      #2;
      check("R11 reach top", pc, 16'hFFFF);
      check("R10 taken low during run", {15'd0, taken}, 16'h0000);
      apply(1'b1, 16'h0000, 3'b000);
      check("R11 wrap to zero", pc, 16'h0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule